// File: doc/BRIEF.md
# Loop-aware next-fetch-address controller

This block owns the program counter of an instruction sequencer. Each cycle it registers the next fetch address. The decoded controls of the instruction fetched two cycles earlier drive it. These controls cover call, return, return-from-interrupt, jump, counted loop start, a delay flag and a target mode, plus an interrupt request line. A single return stack holds three kinds of entry: subroutine return addresses, interrupt return addresses and loop start addresses. A counted loop costs no extra cycles. When the fetch address reaches the loop's last instruction, the next fetch goes back to the loop start with no pipeline bubble.

A branch is either non-delayed or delayed. A non-delayed branch discards the two instructions already in flight and raises a one-cycle squash strobe. A delayed branch lets both of them execute. An interrupt is taken only at a clean instruction boundary. On acceptance the block redirects to a fixed vector and pulses an acknowledge. Stack misuse raises sticky flags.

Top module: `seq_pc_ctl`

## Requirements
- R1: During and after reset, fetch_addr is RST_VEC (default 0x000100) and squash, irq_ack, stk_ovf and stk_unf are 0. Without control activity, fetch_addr then increments by one every cycle.
- R2: The controls apply to the instruction fetched two cycles before the current fetch_addr. A non-delayed jump, call, ret or reti makes the next fetch_addr the target and sets squash for exactly one cycle. Controls presented while the decode slot holds a squashed instruction are ignored. If several are raised, the priority is ret/reti, then call, then jump, then loop start.
- R3: With br_delayed=1, a branch redirects the fetch address without squash, and the two instructions after the branch execute.
- R4: Target selection uses br_mode. 0 selects br_tgt. 1 selects br_reg. 2 selects the decoded instruction's address plus br_tgt as a two's complement offset. 3 behaves as 0.
- R5: A call pushes a return address and a ret pops it as the next fetch address. For a non-delayed call the return address is the instruction after the call. For a delayed call it is the address after the second delay slot.
- R6: op_loop pushes the address that follows the loop instruction as the loop start. The body runs from there to loop_end, which must lie at least three instructions past the loop instruction. When the fetch address equals loop_end with a count above 1, the next fetch is the loop start and the count decrements, with no squash. With a count of 1 or 0, fetch falls through and the loop entry is popped. The body therefore runs max(count,1) times.
- R7: A jump decoded while a loop is active ends the loop and discards the loop entry together with anything above it on the stack. A later fetch of the old loop_end falls through.
- R8: An interrupt is accepted only when the decode slot holds a valid instruction with no branch or loop start, and only once two instructions have been decoded after a delayed branch. On acceptance, fetch goes to IRQ_VEC (default 0x000040), irq_ack and squash pulse for one cycle, and the address of the instruction after the accepted one is pushed.
- R9: No further interrupt is accepted until a reti is decoded. reti pops the stack like ret.
- R10: An accepted interrupt has priority over loop-end detection in the same cycle, and the loop count is then unchanged. An interrupt is deferred while the older in-flight instruction was fetched by a loop-end redirect or termination.
- R11: The stack holds DEPTH (default 30) entries. A push onto a full stack is dropped and sets stk_ovf, which stays set until reset.
- R12: A pop from an empty stack sets stk_unf, which stays set until reset, and the next fetch address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_loop | input | 1 | Decoded loop start |
| loop_cnt | input | CW | Iteration count for the loop start |
| loop_end | input | AW | Address of the last body instruction |
| op_call | input | 1 | Decoded call |
| op_ret | input | 1 | Decoded subroutine return |
| op_reti | input | 1 | Decoded interrupt return |
| op_jump | input | 1 | Decoded jump |
| br_delayed | input | 1 | Branch executes its two delay slots |
| br_mode | input | 2 | Target mode: 0 direct, 1 register, 2 relative |
| br_tgt | input | AW | Direct target or relative offset |
| br_reg | input | AW | Register-supplied target |
| irq | input | 1 | Interrupt request (level) |
| fetch_addr | output | AW | Registered fetch address |
| squash | output | 1 | Discard the two in-flight instructions |
| stk_ovf | output | 1 | Sticky stack overflow |
| stk_unf | output | 1 | Sticky stack underflow |
| irq_ack | output | 1 | Interrupt accepted strobe |

## Verification
The main collision is between a loop-end fetch and an interrupt in decode. A loop is started whose last instruction is fetched in the same cycle as an interrupt request reaches a valid decode slot. The bench then follows the return and confirms the body still runs its full count. The opposite order is also covered: the request arrives just after a loop-back fetch. Here the bench checks that acceptance slips by one instruction and that the pushed return address is the redirected loop start. A jump decoded while a loop is active is also checked. The jump must win, and the later fetch of the old end address must fall through.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    TGT_DIRECT   = 2'd0,
    TGT_REGISTER = 2'd1,
    TGT_RELATIVE = 2'd2,
    TGT_SPARE    = 2'd3
  } tgt_mode_e;
endpackage

// File: rtl/seq_rstack.sv
// Shared return stack: subroutine, interrupt and loop-start entries.
module seq_rstack #(
  parameter int AW    = 24,
  parameter int DEPTH = 30,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          cut,
  input  logic [IW-1:0] cut_ptr,
  input  logic [AW-1:0] wdata,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_data,
  output logic [AW-1:0] top_data,
  output logic [IW-1:0] wr_idx,
  output logic          full,
  output logic          ovf,
  output logic          unf
);
  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr_q;
  logic          empty;
  logic [IW-1:0] top_idx;

  assign full    = (ptr_q == PW'(DEPTH));
  assign empty   = (ptr_q == '0);
  assign wr_idx  = ptr_q[IW-1:0];
  assign top_idx = IW'(ptr_q - 1'b1);
  assign top_data = empty ? '0 : mem[top_idx];
  assign rd_data  = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else if (cut) begin
      ptr_q <= PW'(cut_ptr);
    end else if (push) begin
      if (full) ovf <= 1'b1;
      else      ptr_q <= ptr_q + 1'b1;
    end else if (pop) begin
      if (empty) unf <= 1'b1;
      else       ptr_q <= ptr_q - 1'b1;
    end
  end
endmodule

// File: rtl/seq_loop.sv
// Single active counted loop: end address, remaining count, stack slot.
module seq_loop #(
  parameter int AW = 24,
  parameter int CW = 16,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] s_cnt,
  input  logic [AW-1:0] s_end,
  input  logic [IW-1:0] s_idx,
  input  logic          back,
  input  logic          stop,
  output logic          active,
  output logic          more,
  output logic [AW-1:0] end_addr,
  output logic [IW-1:0] idx
);
  logic [CW-1:0] cnt_q;

  assign more = (cnt_q > CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      cnt_q    <= '0;
      end_addr <= '0;
      idx      <= '0;
    end else if (start) begin
      active   <= 1'b1;
      cnt_q    <= s_cnt;
      end_addr <= s_end;
      idx      <= s_idx;
    end else if (stop) begin
      active <= 1'b0;
    end else if (back) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/seq_pc_ctl.sv
module seq_pc_ctl
  import seq_pkg::*;
#(
  parameter int          AW      = 24,
  parameter int          CW      = 16,
  parameter int          DEPTH   = 30,
  parameter logic [AW-1:0] RST_VEC = 24'h000100,
  parameter logic [AW-1:0] IRQ_VEC = 24'h000040
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_loop,
  input  logic [CW-1:0] loop_cnt,
  input  logic [AW-1:0] loop_end,
  input  logic          op_call,
  input  logic          op_ret,
  input  logic          op_reti,
  input  logic          op_jump,
  input  logic          br_delayed,
  input  logic [1:0]    br_mode,
  input  logic [AW-1:0] br_tgt,
  input  logic [AW-1:0] br_reg,
  input  logic          irq,
  output logic [AW-1:0] fetch_addr,
  output logic          squash,
  output logic          stk_ovf,
  output logic          stk_unf,
  output logic          irq_ack
);
  localparam int IW = $clog2(DEPTH);

  // fetch pipeline: fa = fetching, pa1 = in flight, pa2 = in decode
  logic [AW-1:0] fa_q, pa1_q, pa2_q;
  logic          v1_q, v2_q, le1_q, sq_q, ack_q, in_isr_q;
  logic [1:0]    dly_q;

  logic          d_ret, d_reti, d_call, d_jmp, d_lop, d_br, irq_take, decode_act;
  logic [AW-1:0] seq, tgt, nf, push_val;
  logic          lp_hit, loop_evt;

  logic          st_push, st_pop, st_cut, st_full;
  logic [AW-1:0] st_rd, st_top;
  logic [IW-1:0] st_widx;
  logic          lp_active, lp_more, lp_start, lp_back, lp_stop;
  logic [AW-1:0] lp_end;
  logic [IW-1:0] lp_idx;

  assign seq = fa_q + AW'(1);

  // decode actions, priority ret/reti > call > jump > loop
  assign d_ret  = v2_q && (op_ret || op_reti);
  assign d_reti = v2_q && op_reti;
  assign d_call = v2_q && op_call && !d_ret;
  assign d_jmp  = v2_q && op_jump && !d_ret && !op_call;
  assign d_lop  = v2_q && op_loop && !d_ret && !op_call && !op_jump;
  assign d_br   = d_ret || d_call || d_jmp;

  assign irq_take = v2_q && irq && !in_isr_q && (dly_q == 2'd0) && !le1_q
                    && !d_br && !d_lop;
  assign decode_act = d_br || d_lop || irq_take;

  always_comb begin
    case (tgt_mode_e'(br_mode))
      TGT_REGISTER: tgt = br_reg;
      TGT_RELATIVE: tgt = pa2_q + br_tgt;
      default:      tgt = br_tgt;
    endcase
  end

  // loop-end detection on the address being fetched now
  assign lp_hit   = lp_active && (fa_q == lp_end);
  assign loop_evt = lp_hit && !decode_act;

  // stack control
  assign push_val = (d_call && br_delayed) ? seq : pa1_q;
  assign st_push  = d_call || d_lop || irq_take;
  assign st_pop   = d_ret || (loop_evt && !lp_more);
  assign st_cut   = d_jmp && lp_active;

  // loop control
  assign lp_start = d_lop && !st_full;
  assign lp_back  = loop_evt && lp_more;
  assign lp_stop  = (loop_evt && !lp_more) || st_cut;

  always_comb begin
    if (d_ret)                 nf = st_top;
    else if (d_call || d_jmp)  nf = tgt;
    else if (irq_take)         nf = IRQ_VEC;
    else if (lp_back)          nf = st_rd;
    else                       nf = seq;
  end

  seq_rstack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (st_push),
    .pop      (st_pop),
    .cut      (st_cut),
    .cut_ptr  (lp_idx),
    .wdata    (push_val),
    .rd_idx   (lp_idx),
    .rd_data  (st_rd),
    .top_data (st_top),
    .wr_idx   (st_widx),
    .full     (st_full),
    .ovf      (stk_ovf),
    .unf      (stk_unf)
  );

  seq_loop #(.AW(AW), .CW(CW), .IW(IW)) u_loop (
    .clk      (clk),
    .rst      (rst),
    .start    (lp_start),
    .s_cnt    (loop_cnt),
    .s_end    (loop_end),
    .s_idx    (st_widx),
    .back     (lp_back),
    .stop     (lp_stop),
    .active   (lp_active),
    .more     (lp_more),
    .end_addr (lp_end),
    .idx      (lp_idx)
  );

  logic kill;
  assign kill = (d_br && !br_delayed) || irq_take;

  always_ff @(posedge clk) begin
    if (rst) begin
      fa_q     <= RST_VEC;
      pa1_q    <= '0;
      pa2_q    <= '0;
      v1_q     <= 1'b0;
      v2_q     <= 1'b0;
      le1_q    <= 1'b0;
      sq_q     <= 1'b0;
      ack_q    <= 1'b0;
      in_isr_q <= 1'b0;
      dly_q    <= 2'd0;
    end else begin
      fa_q  <= nf;
      pa1_q <= fa_q;
      pa2_q <= pa1_q;
      v1_q  <= !kill;
      v2_q  <= v1_q && !kill;
      le1_q <= loop_evt;
      sq_q  <= kill;
      ack_q <= irq_take;
      if (irq_take)    in_isr_q <= 1'b1;
      else if (d_reti) in_isr_q <= 1'b0;
      if (d_br && br_delayed)          dly_q <= 2'd2;
      else if (v2_q && dly_q != 2'd0)  dly_q <= dly_q - 2'd1;
    end
  end

  assign fetch_addr = fa_q;
  assign squash     = sq_q;
  assign irq_ack    = ack_q;
endmodule

// File: rtl/seq_pc_ctl_chk.sv
module seq_pc_ctl_chk #(
  parameter int            AW      = 24,
  parameter logic [AW-1:0] IRQ_VEC = 24'h000040
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] fetch_addr,
  input logic          squash,
  input logic          irq_ack,
  input logic          stk_ovf,
  input logic          stk_unf
);
  a_r8_ack_squash: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> squash);
  a_r8_ack_vector: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> fetch_addr == IRQ_VEC);
  a_r2_squash_single: assert property (@(posedge clk) disable iff (rst)
    squash |=> !squash);
  a_r9_ack_gap: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack);
  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    stk_ovf |=> stk_ovf);
  a_r12_unf_sticky: assert property (@(posedge clk) disable iff (rst)
    stk_unf |=> stk_unf);
endmodule

bind seq_pc_ctl seq_pc_ctl_chk #(.AW(AW), .IRQ_VEC(IRQ_VEC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fetch_addr (fetch_addr),
  .squash     (squash),
  .irq_ack    (irq_ack),
  .stk_ovf    (stk_ovf),
  .stk_unf    (stk_unf)
);

// File: tb/seq_pc_ctl_tb.sv
module seq_pc_ctl_tb;
  localparam int AW = 24;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_loop, op_call, op_ret, op_reti, op_jump, br_delayed, irq;
  logic [CW-1:0] loop_cnt;
  logic [AW-1:0] loop_end, br_tgt, br_reg;
  logic [1:0]    br_mode;
  logic [AW-1:0] fetch_addr;
  logic          squash, stk_ovf, stk_unf, irq_ack;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  seq_pc_ctl u_dut (
    .clk(clk), .rst(rst), .op_loop(op_loop), .loop_cnt(loop_cnt),
    .loop_end(loop_end), .op_call(op_call), .op_ret(op_ret),
    .op_reti(op_reti), .op_jump(op_jump), .br_delayed(br_delayed),
    .br_mode(br_mode), .br_tgt(br_tgt), .br_reg(br_reg), .irq(irq),
    .fetch_addr(fetch_addr), .squash(squash), .stk_ovf(stk_ovf),
    .stk_unf(stk_unf), .irq_ack(irq_ack)
  );

  task automatic chk(input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", what, got, exp);
    end
  endtask

  task automatic clr();
    op_loop = 0; op_call = 0; op_ret = 0; op_reti = 0; op_jump = 0;
    br_delayed = 0; br_mode = 2'd0; br_tgt = '0; br_reg = '0; irq = 0;
    loop_cnt = '0; loop_end = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    clr();
    rst = 1;
    step(); step(); step();
    rst = 0;
  endtask

  // leaves decode slot on 0x100, fetch on 0x102
  task automatic go2();
    step(); step();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset fetch", fetch_addr, 32'h100);
    chk("R1 reset squash", squash, 0);
    chk("R1 reset ack", irq_ack, 0);
    chk("R1 reset ovf/unf", {stk_ovf, stk_unf}, 0);
    step();
    chk("R1 sequential", fetch_addr, 32'h101);
    step();
    chk("R1 sequential 2", fetch_addr, 32'h102);
  endtask

  task automatic t_jump();
    do_reset(); go2();
    op_jump = 1; br_mode = 2'd0; br_tgt = 24'h200;
    step();
    chk("R2 R4 direct jump target", fetch_addr, 32'h200);
    chk("R2 jump squash", squash, 1);
    br_tgt = 24'h300;
    step();
    chk("R2 squashed slot ignored", fetch_addr, 32'h201);
    chk("R2 squash one cycle", squash, 0);
    step();
    chk("R2 squashed slot ignored 2", fetch_addr, 32'h202);
    br_mode = 2'd2; br_tgt = 24'hFFFF00;
    step();
    chk("R4 relative negative", fetch_addr, 32'h100);
    clr();
  endtask

  task automatic t_delay_irq();
    do_reset(); go2();
    op_jump = 1; br_delayed = 1; br_mode = 2'd2; br_tgt = 24'h20;
    step();
    chk("R3 R4 delayed relative", fetch_addr, 32'h120);
    chk("R3 no squash", squash, 0);
    clr(); irq = 1;
    step();
    chk("R8 blocked slot1", irq_ack, 0);
    chk("R3 slot1 runs", fetch_addr, 32'h121);
    step();
    chk("R8 blocked slot2", irq_ack, 0);
    step();
    chk("R8 accepted", irq_ack, 1);
    chk("R8 vector", fetch_addr, 32'h40);
    chk("R8 squash", squash, 1);
    step(); step(); step();
    chk("R9 nested blocked", irq_ack, 0);
    chk("R9 isr runs", fetch_addr, 32'h43);
    irq = 0; op_reti = 1;
    step();
    chk("R8 R9 reti return addr", fetch_addr, 32'h121);
    clr(); irq = 1;
    step(); step();
    chk("R9 no ack on squashed", irq_ack, 0);
    step();
    chk("R9 re-enabled", irq_ack, 1);
    clr();
  endtask

  task automatic t_call_ret();
    do_reset(); go2();
    op_call = 1; br_delayed = 1; br_tgt = 24'h300;
    step();
    chk("R5 delayed call", fetch_addr, 32'h300);
    chk("R3 delayed call no squash", squash, 0);
    clr(); step(); step();
    op_ret = 1; br_delayed = 1;
    step();
    chk("R5 delayed return addr", fetch_addr, 32'h103);
    clr(); step(); step();
    op_call = 1; br_mode = 2'd1; br_reg = 24'h500; br_tgt = 24'h7;
    step();
    chk("R4 register target", fetch_addr, 32'h500);
    clr(); step(); step();
    op_ret = 1;
    step();
    chk("R5 return addr", fetch_addr, 32'h104);
    chk("R5 return squash", squash, 1);
    chk("R12 no underflow", stk_unf, 0);
    clr();
  endtask

  task automatic t_loop();
    logic [31:0] exp_seq [8] = '{32'h101, 32'h102, 32'h103, 32'h101,
                                 32'h102, 32'h103, 32'h104, 32'h105};
    do_reset(); go2();
    op_loop = 1; loop_cnt = 16'd3; loop_end = 24'h103;
    step();
    chk("R6 loop start", fetch_addr, 32'h103);
    clr();
    for (int i = 0; i < 8; i++) begin
      step();
      chk($sformatf("R6 loop fetch %0d", i), fetch_addr, exp_seq[i]);
      chk("R6 no bubble", squash, 0);
    end
    do_reset(); go2();
    op_loop = 1; loop_cnt = 16'd1; loop_end = 24'h103;
    step(); clr(); step();
    chk("R6 count one falls through", fetch_addr, 32'h104);
    clr();
  endtask

  task automatic t_abort();
    do_reset(); go2();
    op_loop = 1; loop_cnt = 16'd5; loop_end = 24'h105;
    step(); clr(); step();
    op_jump = 1; br_tgt = 24'h200;
    step();
    chk("R7 jump in loop", fetch_addr, 32'h200);
    clr(); step(); step();
    op_jump = 1; br_tgt = 24'h104;
    step(); clr(); step();
    chk("R7 at old end", fetch_addr, 32'h105);
    step();
    chk("R7 old end falls through", fetch_addr, 32'h106);
    op_ret = 1;
    step();
    chk("R7 R12 entry discarded, underflow", stk_unf, 1);
    chk("R12 empty pop address", fetch_addr, 32'h0);
    clr();
  endtask

  task automatic t_loop_irq();
    do_reset(); go2();
    op_loop = 1; loop_cnt = 16'd2; loop_end = 24'h103;
    step();
    clr(); irq = 1;
    step();
    chk("R10 irq beats loop end", irq_ack, 1);
    chk("R10 vector", fetch_addr, 32'h40);
    irq = 0; step(); step();
    op_reti = 1;
    step();
    chk("R10 return into body", fetch_addr, 32'h102);
    clr();
    step(); chk("R10 body a", fetch_addr, 32'h103);
    step(); chk("R10 count kept", fetch_addr, 32'h101);
    step(); step();
    step(); chk("R10 loop exits", fetch_addr, 32'h104);

    do_reset(); go2();
    op_loop = 1; loop_cnt = 16'd2; loop_end = 24'h103;
    step(); clr(); step();
    chk("R6 loop back", fetch_addr, 32'h101);
    irq = 1;
    step();
    chk("R10 deferred after loop-back", irq_ack, 0);
    step();
    chk("R10 accepted next", irq_ack, 1);
    irq = 0; step(); step();
    op_reti = 1;
    step();
    chk("R10 return to loop start", fetch_addr, 32'h101);
    clr(); step(); step(); step();
    chk("R10 final exit", fetch_addr, 32'h104);
    clr();
  endtask

  task automatic t_stack_full();
    do_reset(); go2();
    for (int i = 0; i < 31; i++) begin
      op_call = 1; br_tgt = 24'h400;
      step();
      clr();
      if (i == 29) chk("R11 no overflow at depth", stk_ovf, 0);
      if (i == 30) chk("R11 overflow on extra push", stk_ovf, 1);
      step(); step();
    end
    for (int i = 0; i < 30; i++) begin
      op_ret = 1;
      step();
      clr();
      if (i == 28) chk("R11 dropped push", fetch_addr, 32'h401);
      if (i == 29) chk("R11 bottom entry", fetch_addr, 32'h101);
      step(); step();
    end
    chk("R12 no underflow yet", stk_unf, 0);
    op_ret = 1;
    step();
    chk("R12 underflow", stk_unf, 1);
    chk("R11 sticky", stk_ovf, 1);
    clr();
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    clr();
    t_reset();
    t_jump();
    t_delay_irq();
    t_call_ret();
    t_loop();
    t_abort();
    t_loop_irq();
    t_stack_full();
    finish_up();
  end
endmodule